// File: doc/BRIEF.md
# USB Endpoint Command and Status Unit

This block holds the per-endpoint state of a full-speed USB device controller across sixteen endpoint slots. Slot 0 is the control OUT endpoint, slot 1 is the control IN endpoint, and slots 2 to 15 are data endpoints 1 to 14. A microcontroller sends single-byte commands that stall, unstall or validate an endpoint. It reads back an 8-bit status word for any slot with a fixed latency of one cycle.

The USB side reports three kinds of event. The first is that a SETUP token was seen. The second is that the setup data has finished being written. The third is that a packet completed on a given buffer half of an endpoint. From these events and the commands, the unit keeps the buffer-full flags, the data PID toggle, a sticky setup-overwrite flag and the CPU-access half of each double buffer up to date.

Two parameters fix the role of each slot. Direction comes from `IN_MASK`; a set bit marks an IN slot. Double buffering comes from `DBL_MASK`. The defaults make the odd slots IN. Slots 2, 3 and 8 to 15 are double buffered. Slots 0, 1 and 4 to 7 are single buffered.

Top module: `usb_ep_status_unit`

## Requirements
- R1: After reset, every slot reads 0x00: unstalled, both halves empty, next PID DATA0, primary half selected.
- R2: Command 0x40+n stalls slot n, setting status bit 7 on the next clock. Stalling slot 0 also clears its setup-held bit, bit 2.
- R3: Command 0x80+n on a stalled slot clears the stall bit and reinitializes the slot, clearing bits 6, 5, 4 and 1. On a slot that is not stalled, it changes nothing.
- R4: Command 0x60+n, with n from 1 to 15, on an IN slot sets the full flag of the selected half: bit 5 when bit 1 is 0, and bit 6 when bit 1 is 1. On an OUT slot the command has no effect. The byte 0x60 has no effect.
- R5: A validate on a double-buffered slot toggles bit 1. On a single-buffered slot, bit 1 stays 0 and only bit 5 is used.
- R6: A SETUP token event (`ev_kind`=1) unstalls and reinitializes slots 0 and 1 if they are stalled, whatever the value of `ev_ep`.
- R7: A setup-done event (`ev_kind`=2) sets bit 2 of slot 0. A SETUP token that arrives while bit 2 is set also sets the overwrite bit, bit 3.
- R8: A read of slot 0 clears bit 3 only when no setup write is pending. A setup write is pending from a SETUP token until the following setup-done. The read itself returns the value from before the clear.
- R9: A packet event (`ev_kind`=3) on a slot that is not stalled toggles bit 4. On an IN slot it clears the full flag of half `ev_half`; on an OUT slot it sets that flag. A packet event on a stalled slot has no effect.
- R10: `rd_data` shows the status of the slot named by `rd_ep` one clock after `rd_en`. Bit 0 is always 0.
- R11: Command bytes outside 0x40-0x4F, 0x80-0x8F and 0x61-0x6F change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command code; the low nibble is the slot |
| ev_kind | input | 2 | USB event: 0 none, 1 SETUP token, 2 setup done, 3 packet done |
| ev_ep | input | 4 | Slot for a packet event |
| ev_half | input | 1 | Buffer half of a packet event (0 primary, 1 secondary) |
| rd_en | input | 1 | Status read strobe |
| rd_ep | input | 4 | Slot to read |
| rd_data | output | 8 | Registered status word |

## Verification
A command or an event changes the slot's state on the clock edge that samples it. A status read returns its data on the edge after the read strobe. Any change caused by one operation is therefore visible to a read issued in the next cycle, and the read data becomes valid one cycle after that.

The bench drives every stimulus on a falling edge and holds it for exactly one cycle. It pushes the expected word when it issues a read, and it pops and compares that word on the falling edge after the read strobe was registered. The sticky-bit case reads the same slot again in later cycles to show that the clear on read takes effect only after the word has been returned.

// File: rtl/usb_epsu_pkg.sv
package usb_epsu_pkg;

    localparam int EP_COUNT = 16;
    localparam int EP_IDX_W = $clog2(EP_COUNT);

    localparam logic [3:0] OP_STALL    = 4'h4;
    localparam logic [3:0] OP_VALIDATE = 4'h6;
    localparam logic [3:0] OP_UNSTALL  = 4'h8;

    typedef enum logic [1:0] {
        EV_NONE       = 2'd0,
        EV_SETUP_TOK  = 2'd1,
        EV_SETUP_DONE = 2'd2,
        EV_PKT_DONE   = 2'd3
    } usb_ev_e;

    typedef struct packed {
        logic stall;
        logic full_sec;
        logic full_pri;
        logic pid;
        logic ovw;
        logic setup_held;
        logic cpu_sel;
        logic rsvd;
    } ep_stat_t;

    typedef struct packed {
        logic                stall;
        logic                unstall;
        logic                validate;
        logic [EP_IDX_W-1:0] ep;
    } cmd_req_t;

    function automatic ep_stat_t ep_reinit(input ep_stat_t s);
        ep_stat_t r;
        r          = s;
        r.stall    = 1'b0;
        r.full_sec = 1'b0;
        r.full_pri = 1'b0;
        r.pid      = 1'b0;
        r.cpu_sel  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/usb_epsu_cmd_decode.sv
module usb_epsu_cmd_decode
    import usb_epsu_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output cmd_req_t   req
);
    logic [3:0] op;
    logic [3:0] idx;

    assign op  = cmd_byte[7:4];
    assign idx = cmd_byte[3:0];

    always_comb begin
        req          = '0;
        req.ep       = idx;
        req.stall    = cmd_valid && (op == OP_STALL);
        req.unstall  = cmd_valid && (op == OP_UNSTALL);
        req.validate = cmd_valid && (op == OP_VALIDATE) && (idx != 4'd0);
    end
endmodule

// File: rtl/usb_epsu_ep_slot.sv
module usb_epsu_ep_slot
    import usb_epsu_pkg::*;
#(
    parameter int IDX    = 0,
    parameter bit IS_IN  = 1'b0,
    parameter bit IS_DBL = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_req_t            req,
    input  usb_ev_e             ev_kind,
    input  logic [EP_IDX_W-1:0] ev_ep,
    input  logic                ev_half,
    input  logic                rd_hit,
    input  logic                setup_busy,
    output ep_stat_t            stat
);
    localparam bit IS_CTRL     = (IDX < 2);
    localparam bit IS_CTRL_OUT = (IDX == 0);
    localparam logic [EP_IDX_W-1:0] MY_IDX = EP_IDX_W'(IDX);

    ep_stat_t st_q;
    ep_stat_t st_d;
    logic     cmd_hit;
    logic     pkt_hit;

    assign cmd_hit = (req.ep == MY_IDX);
    assign pkt_hit = (ev_kind == EV_PKT_DONE) && (ev_ep == MY_IDX) && !st_q.stall;

    always_comb begin
        st_d = st_q;

        // read-side clear first, so a same-cycle set wins
        if (IS_CTRL_OUT && rd_hit && !setup_busy) begin
            st_d.ovw = 1'b0;
        end

        if (ev_kind == EV_SETUP_TOK) begin
            if (IS_CTRL && st_q.stall) begin
                st_d = ep_reinit(st_d);
            end
            if (IS_CTRL_OUT && st_q.setup_held) begin
                st_d.ovw = 1'b1;
            end
        end

        if (IS_CTRL_OUT && ev_kind == EV_SETUP_DONE) begin
            st_d.setup_held = 1'b1;
        end

        if (pkt_hit) begin
            st_d.pid = ~st_q.pid;
            if (ev_half) begin
                st_d.full_sec = !IS_IN;
            end else begin
                st_d.full_pri = !IS_IN;
            end
        end

        if (cmd_hit && req.stall) begin
            st_d.stall = 1'b1;
            if (IS_CTRL_OUT) begin
                st_d.setup_held = 1'b0;
            end
        end

        if (cmd_hit && req.unstall && st_d.stall) begin
            st_d = ep_reinit(st_d);
        end

        if (IS_IN && cmd_hit && req.validate) begin
            if (IS_DBL) begin
                if (st_d.cpu_sel) begin
                    st_d.full_sec = 1'b1;
                end else begin
                    st_d.full_pri = 1'b1;
                end
                st_d.cpu_sel = ~st_d.cpu_sel;
            end else begin
                st_d.full_pri = 1'b1;
            end
        end

        st_d.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q;
endmodule

// File: rtl/usb_epsu_rd_port.sv
module usb_epsu_rd_port
    import usb_epsu_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  logic [EP_IDX_W-1:0]           rd_ep,
    input  logic [EP_COUNT-1:0][7:0]      status_all,
    output logic [7:0]                    rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= 8'h00;
        end else if (rd_en) begin
            rd_data <= {status_all[rd_ep][7:1], 1'b0};
        end
    end
endmodule

// File: rtl/usb_ep_status_unit.sv
module usb_ep_status_unit
    import usb_epsu_pkg::*;
#(
    parameter logic [EP_COUNT-1:0] IN_MASK  = 16'hAAAA,
    parameter logic [EP_COUNT-1:0] DBL_MASK = 16'hFF0C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic [1:0] ev_kind,
    input  logic [3:0] ev_ep,
    input  logic       ev_half,
    input  logic       rd_en,
    input  logic [3:0] rd_ep,
    output logic [7:0] rd_data
);
    cmd_req_t                   req;
    usb_ev_e                    ev;
    logic                       setup_busy;
    logic                       rd_ctrl_out;
    logic [EP_COUNT-1:0][7:0]   status_all;

    assign ev          = usb_ev_e'(ev_kind);
    assign rd_ctrl_out = rd_en && (rd_ep == '0);

    usb_epsu_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .req       (req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_busy <= 1'b0;
        end else if (ev == EV_SETUP_TOK) begin
            setup_busy <= 1'b1;
        end else if (ev == EV_SETUP_DONE) begin
            setup_busy <= 1'b0;
        end
    end

    for (genvar g = 0; g < EP_COUNT; g++) begin : g_slot
        usb_epsu_ep_slot #(
            .IDX    (g),
            .IS_IN  (IN_MASK[g]),
            .IS_DBL (DBL_MASK[g])
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .req        (req),
            .ev_kind    (ev),
            .ev_ep      (ev_ep),
            .ev_half    (ev_half),
            .rd_hit     (rd_ctrl_out),
            .setup_busy (setup_busy),
            .stat       (status_all[g])
        );
    end

    usb_epsu_rd_port u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .rd_ep      (rd_ep),
        .status_all (status_all),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/usb_ep_status_unit_chk.sv
module usb_ep_status_unit_chk (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [7:0]        cmd_byte,
    input logic [1:0]        ev_kind,
    input logic              rd_en,
    input logic [3:0]        rd_ep,
    input logic [7:0]        rd_data,
    input logic [15:0][7:0]  status_all
);
    a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[0] == 1'b0);

    a_r10_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_data[7:1] == $past(status_all[rd_ep][7:1]));

    a_r2_stall_sets: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte[7:4] == 4'h4) |=> status_all[$past(cmd_byte[3:0])][7]);

    a_r3_unstall_reinit: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte[7:4] == 4'h8 && status_all[cmd_byte[3:0]][7])
        |=> status_all[$past(cmd_byte[3:0])][7:4] == 4'h0
            && status_all[$past(cmd_byte[3:0])][1] == 1'b0);

    a_r6_setup_unstalls: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == 2'd1 && !(cmd_valid && cmd_byte[7:4] == 4'h4 && cmd_byte[3:1] == 3'd0))
        |=> !status_all[0][7] && !status_all[1][7]);

    a_r8_ovw_sticky: assert property (@(posedge clk) disable iff (rst)
        (status_all[0][3] && !(rd_en && rd_ep == 4'd0)) |=> status_all[0][3]);
endmodule

bind usb_ep_status_unit usb_ep_status_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .ev_kind    (ev_kind),
    .rd_en      (rd_en),
    .rd_ep      (rd_ep),
    .rd_data    (rd_data),
    .status_all (status_all)
);

// File: tb/usb_ep_status_unit_tb.sv
module usb_ep_status_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [1:0] ev_kind = 2'd0;
    logic [3:0] ev_ep = 4'd0;
    logic       ev_half = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_ep = 4'd0;
    logic [7:0] rd_data;

    localparam logic [15:0] IN_M  = 16'hAAAA;
    localparam logic [15:0] DBL_M = 16'hFF0C;

    usb_ep_status_unit #(.IN_MASK(IN_M), .DBL_MASK(DBL_M)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .ev_kind(ev_kind), .ev_ep(ev_ep), .ev_half(ev_half),
        .rd_en(rd_en), .rd_ep(rd_ep), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    // expected model, built from the requirements
    logic [7:0] m [16];
    logic       m_busy;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    int         n_vec = 0;
    int         n_bad = 0;
    logic       rd_q = 1'b0;

    function automatic logic [7:0] reinit_v(input logic [7:0] v);
        return v & 8'b0000_1100;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_cmd(input logic [7:0] b);
        logic [3:0] n;
        n = b[3:0];
        cmd_valid = 1'b1;
        cmd_byte  = b;
        if (b[7:4] == 4'h4) begin
            m[n][7] = 1'b1;
            if (n == 4'd0) m[n][2] = 1'b0;
        end else if (b[7:4] == 4'h8) begin
            if (m[n][7]) m[n] = reinit_v(m[n]);
        end else if (b[7:4] == 4'h6 && n != 4'd0 && IN_M[n]) begin
            if (DBL_M[n]) begin
                if (m[n][1]) m[n][6] = 1'b1; else m[n][5] = 1'b1;
                m[n][1] = ~m[n][1];
            end else begin
                m[n][5] = 1'b1;
            end
        end
        tick();
        cmd_valid = 1'b0;
        cmd_byte  = 8'h00;
    endtask

    task automatic do_ev(input logic [1:0] k, input logic [3:0] e, input logic h);
        ev_kind = k; ev_ep = e; ev_half = h;
        if (k == 2'd1) begin
            for (int i = 0; i < 2; i++) if (m[i][7]) m[i] = reinit_v(m[i]);
            if (m[0][2]) m[0][3] = 1'b1;
            m_busy = 1'b1;
        end else if (k == 2'd2) begin
            m[0][2] = 1'b1;
            m_busy = 1'b0;
        end else if (k == 2'd3 && !m[e][7]) begin
            m[e][4] = ~m[e][4];
            if (h) m[e][6] = !IN_M[e]; else m[e][5] = !IN_M[e];
        end
        tick();
        ev_kind = 2'd0; ev_ep = 4'd0; ev_half = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] e, input string tag);
        rd_en = 1'b1; rd_ep = e;
        exp_q.push_back(m[e]);
        tag_q.push_back(tag);
        if (e == 4'd0 && !m_busy) m[0][3] = 1'b0;
        tick();
        rd_en = 1'b0; rd_ep = 4'd0;
    endtask

    always @(posedge clk) rd_q <= rst ? 1'b0 : rd_en;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rd_q && exp_q.size() > 0) begin
            logic [7:0] ex;
            string      tg;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_vec++;
            if (rd_data !== ex) begin
                n_bad++;
                $display("FAIL %s: rd_data=%02h expected=%02h", tg, rd_data, ex);
            end
        end
    end

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m[i] = 8'h00;
        m_busy = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 / R10: reset state of every slot
        for (int i = 0; i < 16; i++) do_read(4'(i), "R1");

        // R2, R3: stall and unstall
        do_cmd(8'h45); do_read(4'd5, "R2");
        do_cmd(8'h85); do_read(4'd5, "R3");

        // R4, R5: validate on double-buffered IN slot 3
        do_cmd(8'h63); do_read(4'd3, "R5");
        do_cmd(8'h63); do_read(4'd3, "R4");
        do_cmd(8'h83); do_read(4'd3, "R3");   // not stalled: no change
        do_cmd(8'h43); do_read(4'd3, "R2");
        do_cmd(8'h83); do_read(4'd3, "R3");

        // R5: single-buffered IN slot 5
        do_cmd(8'h65); do_read(4'd5, "R5");
        do_cmd(8'h65); do_read(4'd5, "R5");

        // R4: OUT slot and 0x60 ignored
        do_cmd(8'h64); do_read(4'd4, "R4");
        do_cmd(8'h60); do_read(4'd0, "R4");

        // R11: undefined codes
        do_cmd(8'h00); do_cmd(8'h30); do_cmd(8'h55); do_cmd(8'hC5);
        do_cmd(8'hFF); do_cmd(8'h75); do_cmd(8'h25);
        do_read(4'd5, "R11"); do_read(4'd0, "R11"); do_read(4'd3, "R11");

        // R9: packet events
        do_ev(2'd3, 4'd5, 1'b0); do_read(4'd5, "R9");
        do_ev(2'd3, 4'd2, 1'b1); do_read(4'd2, "R9");
        do_cmd(8'h42);
        do_ev(2'd3, 4'd2, 1'b0); do_read(4'd2, "R9");
        do_cmd(8'h82); do_read(4'd2, "R3");

        // R6: SETUP unstalls control slots
        do_cmd(8'h40); do_cmd(8'h41); do_cmd(8'h61);
        do_read(4'd1, "R4");
        do_ev(2'd1, 4'd9, 1'b0);
        do_read(4'd1, "R6"); do_read(4'd0, "R6");

        // R7, R8: setup held, overwrite, sticky clear
        do_ev(2'd2, 4'd0, 1'b0); do_read(4'd0, "R7");
        do_ev(2'd1, 4'd0, 1'b0); do_read(4'd0, "R7");
        do_read(4'd0, "R8");
        do_ev(2'd2, 4'd0, 1'b0);
        do_read(4'd0, "R8"); do_read(4'd0, "R8");
        do_cmd(8'h40); do_read(4'd0, "R2");
        do_ev(2'd1, 4'd0, 1'b0); do_read(4'd0, "R6");
        do_ev(2'd2, 4'd0, 1'b0); do_read(4'd0, "R7");

        repeat (4) tick();
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: pending=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule